// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block carries received Ethernet frames from a switch core into host memory through a circular list of descriptors that the host CPU maintains. Each descriptor occupies four consecutive 32-bit words, 16-byte aligned. Word 0 holds the primary buffer address together with the ownership flag and the end-of-ring flag. Word 1 holds an optional secondary buffer address and its enable bit. Word 2 holds the buffer capacities. Word 3 receives the completion status. The host fills descriptors with empty buffers, sets their ownership flag and lets the engine run.

When a frame starts on the input stream, the engine reads the current descriptor. If the engine owns it, the engine writes the payload words into the buffer or buffers, truncating at the available capacity. It then writes the status word and finally writes word 0 back with the ownership flag cleared, which returns the descriptor to the CPU and raises a completion pulse. If the CPU still holds the descriptor, the frame is consumed and discarded, a no-descriptor pulse is raised, and the same descriptor is tried again for the next frame.

The controller is a single state machine. The states are:

- `ST_IDLE`: moves to `ST_FETCH_B1` on a frame start, issuing the read of word 0.
- `ST_FETCH_B1`: moves to `ST_FETCH_B2`.
- `ST_FETCH_B2`: moves to `ST_FETCH_LEN`.
- `ST_FETCH_LEN`: moves to `ST_MOVE` when the descriptor is owned, otherwise to `ST_DISCARD`.
- `ST_MOVE`: moves to `ST_PUT_STATUS` on the last beat.
- `ST_DISCARD`: moves to `ST_IDLE` on the last beat.
- `ST_PUT_STATUS`: moves to `ST_RELEASE`.
- `ST_RELEASE`: moves to `ST_IDLE`.

Top module: `rxr_dma_writer`

## Requirements
- R1: After reset `fs_ready`, `mem_req`, `irq_rx_done` and `irq_no_desc` are low, and the first descriptor fetched is at `ring_base`.
- R2: When a frame starts, the engine reads descriptor words at offsets 0, 4 and 8 from the current descriptor address on three consecutive cycles, and issues no other reads for that frame.
- R3: For an owned descriptor, payload word k (bytes 4k..4k+3) is written to primary buffer address (word 0 bits 24:0) plus 4k whenever 4k is below the stored length.
- R4: Before release, the status word is written at descriptor offset 12 with these fields: stored length in bits 26:16 (the frame length including the 4-byte checksum), source port in bits 14:12, IP-checksum-fail in bit 3, VLAN-tag-present in bit 2, packet type in bits 1:0. All other bits are zero.
- R5: After the status word, word 0 is rewritten at offset 0 with bit 31 (ownership) cleared and all other bits unchanged. `irq_rx_done` pulses in that same cycle.
- R6: After a release, the next descriptor is the current one plus 16, or `ring_base` when bit 28 (end of ring) of word 0 was set.
- R7: If bit 31 of word 0 is clear, the whole frame is consumed with no memory write and `irq_no_desc` pulses for one cycle. The next frame fetches the same descriptor again.
- R8: When bit 31 of word 1 is set, bytes at offsets at or beyond the primary capacity (word 2 bits 10:0) go to the secondary address (word 1 bits 24:0) plus (offset minus primary capacity). The secondary capacity is word 2 bits 26:16. Without that bit, the whole frame targets the primary buffer.
- R9: A frame longer than the total capacity is truncated: words past the capacity are not written, and the status length field reports the capacity.
- R10: `fs_ready` is low while a descriptor is being fetched (four cycles from an idle frame start) and high in `ST_MOVE` and `ST_DISCARD`, where one beat per cycle is accepted.
- R11: `irq_rx_done` and `irq_no_desc` are single-cycle pulses, never high together, one per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base | input | ADDR_W | Byte address of descriptor 0, 16-byte aligned |
| fs_valid | input | 1 | Frame beat valid |
| fs_ready | output | 1 | Frame beat accepted |
| fs_data | input | 32 | Payload word, lowest byte offset first |
| fs_last | input | 1 | Final beat of the frame |
| fs_src_port | input | 3 | Ingress port, held for the whole frame |
| fs_len | input | 11 | Frame byte count including checksum, held for the frame |
| fs_vlan_tag | input | 1 | Frame carried a VLAN tag |
| fs_ip_csum_bad | input | 1 | IP header checksum failed |
| fs_pkt_type | input | 2 | Packet class (0 IP, 1 PPPoE) |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after the read |
| irq_rx_done | output | 1 | Descriptor returned to CPU |
| irq_no_desc | output | 1 | Frame dropped, descriptor not owned |

## Verification
Two events coincide in `ST_RELEASE`: the ownership hand-back of a descriptor (with its completion pulse) and the reload of the ring pointer to the base when that descriptor carries the end-of-ring flag. The bench provokes this by placing a split-buffer frame in the last ring slot, directly after a dropped attempt on the same slot. It then judges three things: the rewritten word 0 keeps bit 28 while losing bit 31, exactly one completion pulse is seen, and the following frame's first descriptor read lands on `ring_base`, not 16 bytes further on.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int WORD_W     = 32;
    localparam int LEN_W      = 11;
    localparam int PORT_W     = 3;
    localparam int BUF_ADDR_W = 25;
    localparam int OWN_BIT    = 31;
    localparam int WRAP_BIT   = 28;
    localparam int EXT_EN_BIT = 31;
    localparam int LEN_LSB    = 16;
    localparam int PORT_LSB   = 12;
    localparam int IPF_BIT    = 3;
    localparam int VTAG_BIT   = 2;
    localparam int PTYPE_W    = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_B1,
        ST_FETCH_B2,
        ST_FETCH_LEN,
        ST_MOVE,
        ST_DISCARD,
        ST_PUT_STATUS,
        ST_RELEASE
    } rx_state_e;

    typedef struct packed {
        logic [PORT_W-1:0]  port;
        logic [LEN_W-1:0]   len;
        logic               vtag;
        logic               ipfail;
        logic [PTYPE_W-1:0] ptype;
    } rx_hdr_t;

    function automatic logic [WORD_W-1:0] pack_status(input rx_hdr_t h,
                                                      input logic [LEN_W-1:0] stored);
        logic [WORD_W-1:0] w;
        w                        = '0;
        w[LEN_LSB +: LEN_W]      = stored;
        w[PORT_LSB +: PORT_W]    = h.port;
        w[IPF_BIT]               = h.ipfail;
        w[VTAG_BIT]              = h.vtag;
        w[PTYPE_W-1:0]           = h.ptype;
        return w;
    endfunction
endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic              step,
    input  logic              wrap,
    output logic [ADDR_W-1:0] desc_addr
);
    localparam int STRIDE = 16;

    logic [OFF_W-1:0] off_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q <= '0;
        end else if (step) begin
            off_q <= wrap ? '0 : off_q + OFF_W'(STRIDE);
        end
    end

    assign desc_addr = ring_base + ADDR_W'(off_q);
endmodule

// File: rtl/rxr_place.sv
module rxr_place
    import rxr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = LEN_W - 1
) (
    input  logic [BUF_ADDR_W-1:0] buf1_base,
    input  logic [BUF_ADDR_W-1:0] buf2_base,
    input  logic                  ext_en,
    input  logic [LEN_W-1:0]      cap1,
    input  logic [LEN_W-1:0]      cap2,
    input  logic [LEN_W-1:0]      frame_len,
    input  logic [IDX_W-1:0]      word_idx,
    output logic [LEN_W-1:0]      keep_len,
    output logic                  word_keep,
    output logic [ADDR_W-1:0]     word_addr
);
    localparam int CAP_W = LEN_W + 1;

    logic [CAP_W-1:0] cap_first;
    logic [CAP_W-1:0] cap_second;
    logic [CAP_W-1:0] cap_total;
    logic [CAP_W-1:0] byte_off;
    logic             in_first;

    assign cap_first  = CAP_W'(cap1);
    assign cap_second = ext_en ? CAP_W'(cap2) : '0;
    assign cap_total  = cap_first + cap_second;
    assign byte_off   = CAP_W'({word_idx, 2'b00});

    always_comb begin
        if (CAP_W'(frame_len) > cap_total) begin
            keep_len = cap_total[LEN_W-1:0];
        end else begin
            keep_len = frame_len;
        end
    end

    assign word_keep = byte_off < CAP_W'(keep_len);
    assign in_first  = byte_off < cap_first;

    always_comb begin
        if (in_first) begin
            word_addr = ADDR_W'(buf1_base) + ADDR_W'(byte_off);
        end else begin
            word_addr = ADDR_W'(buf2_base) + ADDR_W'(byte_off - cap_first);
        end
    end
endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
    import rxr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = LEN_W - 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fs_valid,
    input  logic                  fs_last,
    input  logic [WORD_W-1:0]     fs_data,
    input  rx_hdr_t               hdr_in,
    output logic                  fs_ready,
    input  logic [ADDR_W-1:0]     desc_addr,
    input  logic [LEN_W-1:0]      keep_len,
    input  logic                  word_keep,
    input  logic [ADDR_W-1:0]     word_addr,
    output logic [IDX_W-1:0]      word_idx,
    output logic [LEN_W-1:0]      frame_len,
    output logic [BUF_ADDR_W-1:0] buf1_base,
    output logic [BUF_ADDR_W-1:0] buf2_base,
    output logic                  ext_en,
    output logic [LEN_W-1:0]      cap1,
    output logic [LEN_W-1:0]      cap2,
    output logic                  ring_step,
    output logic                  ring_wrap,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [WORD_W-1:0]     mem_wdata,
    input  logic [WORD_W-1:0]     mem_rdata,
    output logic                  irq_done,
    output logic                  irq_nodesc
);
    localparam logic [ADDR_W-1:0] OFS_EXT  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFS_SIZE = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(12);
    localparam logic [IDX_W-1:0]  IDX_MAX  = '1;

    rx_state_e             state_q, state_d;
    rx_hdr_t               hdr_q;
    logic [WORD_W-1:0]     buf1_q;
    logic [BUF_ADDR_W-1:0] buf2_q;
    logic                  ext_q;
    logic [LEN_W-1:0]      cap1_q, cap2_q;
    logic [IDX_W-1:0]      idx_q;
    logic                  owned;
    logic                  beat;

    assign owned = buf1_q[OWN_BIT];
    assign beat  = fs_valid && fs_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (fs_valid) state_d = ST_FETCH_B1;
            ST_FETCH_B1:   state_d = ST_FETCH_B2;
            ST_FETCH_B2:   state_d = ST_FETCH_LEN;
            ST_FETCH_LEN:  state_d = owned ? ST_MOVE : ST_DISCARD;
            ST_MOVE:       if (fs_valid && fs_last) state_d = ST_PUT_STATUS;
            ST_DISCARD:    if (fs_valid && fs_last) state_d = ST_IDLE;
            ST_PUT_STATUS: state_d = ST_RELEASE;
            ST_RELEASE:    state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        fs_ready   = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = desc_addr;
        mem_wdata  = '0;
        irq_done   = 1'b0;
        irq_nodesc = 1'b0;
        ring_step  = 1'b0;
        ring_wrap  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                mem_req = fs_valid;
            end
            ST_FETCH_B1: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + OFS_EXT;
            end
            ST_FETCH_B2: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + OFS_SIZE;
            end
            ST_FETCH_LEN: begin
                irq_nodesc = !owned;
            end
            ST_MOVE: begin
                fs_ready  = 1'b1;
                mem_req   = fs_valid && word_keep;
                mem_we    = 1'b1;
                mem_addr  = word_addr;
                mem_wdata = fs_data;
            end
            ST_DISCARD: begin
                fs_ready = 1'b1;
            end
            ST_PUT_STATUS: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr + OFS_STAT;
                mem_wdata = pack_status(hdr_q, keep_len);
            end
            ST_RELEASE: begin
                mem_req            = 1'b1;
                mem_we             = 1'b1;
                mem_wdata          = buf1_q;
                mem_wdata[OWN_BIT] = 1'b0;
                irq_done           = 1'b1;
                ring_step          = 1'b1;
                ring_wrap          = buf1_q[WRAP_BIT];
            end
            default: ;
        endcase
    end

    // descriptor and frame context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_q  <= '0;
            buf1_q <= '0;
            buf2_q <= '0;
            ext_q  <= 1'b0;
            cap1_q <= '0;
            cap2_q <= '0;
            idx_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (fs_valid) begin
                        hdr_q <= hdr_in;
                        idx_q <= '0;
                    end
                end
                ST_FETCH_B1: buf1_q <= mem_rdata;
                ST_FETCH_B2: begin
                    buf2_q <= mem_rdata[BUF_ADDR_W-1:0];
                    ext_q  <= mem_rdata[EXT_EN_BIT];
                end
                ST_FETCH_LEN: begin
                    cap1_q <= mem_rdata[LEN_W-1:0];
                    cap2_q <= mem_rdata[LEN_LSB +: LEN_W];
                end
                ST_MOVE: begin
                    if (beat && idx_q != IDX_MAX) begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign word_idx  = idx_q;
    assign frame_len = hdr_q.len;
    assign buf1_base = buf1_q[BUF_ADDR_W-1:0];
    assign buf2_base = buf2_q;
    assign ext_en    = ext_q;
    assign cap1      = cap1_q;
    assign cap2      = cap2_q;
endmodule

// File: rtl/rxr_dma_writer.sv
module rxr_dma_writer
    import rxr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  ring_base,
    input  logic               fs_valid,
    output logic               fs_ready,
    input  logic [WORD_W-1:0]  fs_data,
    input  logic               fs_last,
    input  logic [PORT_W-1:0]  fs_src_port,
    input  logic [LEN_W-1:0]   fs_len,
    input  logic               fs_vlan_tag,
    input  logic               fs_ip_csum_bad,
    input  logic [PTYPE_W-1:0] fs_pkt_type,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               irq_rx_done,
    output logic               irq_no_desc
);
    localparam int IDX_W = LEN_W - 1;

    rx_hdr_t               hdr_in;
    logic [ADDR_W-1:0]     desc_addr;
    logic                  ring_step, ring_wrap;
    logic [IDX_W-1:0]      word_idx;
    logic [LEN_W-1:0]      frame_len, keep_len, cap1, cap2;
    logic [BUF_ADDR_W-1:0] buf1_base, buf2_base;
    logic                  ext_en, word_keep;
    logic [ADDR_W-1:0]     word_addr;

    assign hdr_in = '{port: fs_src_port, len: fs_len, vtag: fs_vlan_tag,
                      ipfail: fs_ip_csum_bad, ptype: fs_pkt_type};

    rxr_ring_ptr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ring_base (ring_base),
        .step      (ring_step),
        .wrap      (ring_wrap),
        .desc_addr (desc_addr)
    );

    rxr_place #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_place (
        .buf1_base (buf1_base),
        .buf2_base (buf2_base),
        .ext_en    (ext_en),
        .cap1      (cap1),
        .cap2      (cap2),
        .frame_len (frame_len),
        .word_idx  (word_idx),
        .keep_len  (keep_len),
        .word_keep (word_keep),
        .word_addr (word_addr)
    );

    rxr_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fs_valid   (fs_valid),
        .fs_last    (fs_last),
        .fs_data    (fs_data),
        .hdr_in     (hdr_in),
        .fs_ready   (fs_ready),
        .desc_addr  (desc_addr),
        .keep_len   (keep_len),
        .word_keep  (word_keep),
        .word_addr  (word_addr),
        .word_idx   (word_idx),
        .frame_len  (frame_len),
        .buf1_base  (buf1_base),
        .buf2_base  (buf2_base),
        .ext_en     (ext_en),
        .cap1       (cap1),
        .cap2       (cap2),
        .ring_step  (ring_step),
        .ring_wrap  (ring_wrap),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .irq_done   (irq_rx_done),
        .irq_nodesc (irq_no_desc)
    );
endmodule

// File: rtl/rxr_checker.sv
module rxr_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fs_valid,
    input logic              fs_ready,
    input logic              fs_last,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              irq_rx_done,
    input logic              irq_no_desc
);
    logic dropping;
    logic rd_cyc, wr_cyc;

    assign rd_cyc = mem_req && !mem_we;
    assign wr_cyc = mem_req && mem_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dropping <= 1'b0;
        end else if (irq_no_desc) begin
            dropping <= 1'b1;
        end else if (fs_valid && fs_ready && fs_last) begin
            dropping <= 1'b0;
        end
    end

    assert_irq_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_rx_done && irq_no_desc));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx_done |=> !irq_rx_done);

    assert_nodesc_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_no_desc |=> !irq_no_desc);

    assert_release_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx_done |-> (wr_cyc && !mem_wdata[31] && mem_addr[3:0] == 4'h0));

    assert_status_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx_done |-> $past(wr_cyc && mem_addr[3:0] == 4'hC));

    assert_drop_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dropping |-> !wr_cyc);

    assert_no_read_while_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fs_ready |-> !rd_cyc);

    assert_fetch_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cyc && mem_addr[3:0] == 4'h8) |-> $past(rd_cyc && mem_addr[3:0] == 4'h4));
endmodule

bind rxr_dma_writer rxr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fs_valid    (fs_valid),
    .fs_ready    (fs_ready),
    .fs_last     (fs_last),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .irq_rx_done (irq_rx_done),
    .irq_no_desc (irq_no_desc)
);

// File: tb/tb_rxr_dma_writer.sv
`timescale 1ns/1ps
module tb_rxr_dma_writer;
    localparam logic [31:0] BASE = 32'h100;
    localparam logic [31:0] B1   = 32'h400;
    localparam logic [31:0] B2   = 32'h800;
    localparam logic [31:0] SENT = 32'hDEAD_BEEF;
    localparam int NB1 = 20;
    localparam int NB2 = 10;

    typedef struct packed {
        logic        own;
        logic        eor;
        logic        ext;
        logic [10:0] cap1;
        logic [10:0] cap2;
        logic [10:0] len;
        logic [2:0]  port;
        logic        vtag;
        logic        ipf;
        logic [1:0]  ptype;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b0, 11'd1550, 11'd0,  11'd64, 3'd1, 1'b0, 1'b0, 2'd0},
        '{1'b1, 1'b0, 1'b0, 11'd1550, 11'd0,  11'd13, 3'd5, 1'b1, 1'b1, 2'd1},
        '{1'b0, 1'b1, 1'b0, 11'd1550, 11'd0,  11'd20, 3'd2, 1'b0, 1'b0, 2'd0},
        '{1'b1, 1'b1, 1'b1, 11'd16,   11'd32, 11'd40, 3'd3, 1'b0, 1'b1, 2'd0},
        '{1'b1, 1'b0, 1'b0, 11'd24,   11'd0,  11'd60, 3'd4, 1'b1, 1'b0, 2'd2},
        '{1'b1, 1'b0, 1'b1, 11'd8,    11'd8,  11'd30, 3'd0, 1'b1, 1'b0, 2'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fs_valid = 1'b0, fs_last = 1'b0;
    logic [31:0] fs_data = '0;
    logic [2:0]  fs_src_port = '0;
    logic [10:0] fs_len = '0;
    logic        fs_vlan_tag = 1'b0, fs_ip_csum_bad = 1'b0;
    logic [1:0]  fs_pkt_type = '0;
    logic        fs_ready, mem_req, mem_we, irq_rx_done, irq_no_desc;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] rdata_q = '0;

    always #2.5 clk = ~clk;

    rxr_dma_writer dut (
        .clk(clk), .rst_n(rst_n), .ring_base(BASE),
        .fs_valid(fs_valid), .fs_ready(fs_ready), .fs_data(fs_data), .fs_last(fs_last),
        .fs_src_port(fs_src_port), .fs_len(fs_len), .fs_vlan_tag(fs_vlan_tag),
        .fs_ip_csum_bad(fs_ip_csum_bad), .fs_pkt_type(fs_pkt_type),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(rdata_q), .irq_rx_done(irq_rx_done), .irq_no_desc(irq_no_desc)
    );

    // memory model, one-cycle read latency
    logic [31:0] mem [0:1023];
    logic        set_en = 1'b0;
    logic [31:0] set_addr = '0, set_val = '0;
    always @(posedge clk) begin
        if (set_en) mem[set_addr[11:2]] <= set_val;
        if (mem_req) begin
            if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
            rdata_q <= mem[mem_addr[11:2]];
        end
    end

    // port monitor
    logic        clr = 1'b0;
    int          n_wr = 0, n_done = 0, n_nodesc = 0, n_rd = 0;
    logic [31:0] rd_log [3];
    always @(posedge clk) begin
        if (clr) begin
            n_wr <= 0; n_done <= 0; n_nodesc <= 0; n_rd <= 0;
        end else begin
            if (mem_req && mem_we) n_wr <= n_wr + 1;
            if (irq_rx_done) n_done <= n_done + 1;
            if (irq_no_desc) n_nodesc <= n_nodesc + 1;
            if (mem_req && !mem_we) begin
                if (n_rd < 3) rd_log[n_rd] <= mem_addr;
                n_rd <= n_rd + 1;
            end
        end
    end

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [31:0] eb1 [NB1];
    logic [31:0] eb2 [NB2];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] v);
        @(negedge clk);
        set_en = 1'b1; set_addr = a; set_val = v;
    endtask

    function automatic logic [31:0] pat(input int i, input int k);
        return 32'hC0DE_0000 | (i << 8) | k;
    endfunction

    task automatic send_frame(input vec_t v, input int tag, output int waits);
        int beats;
        beats = (int'(v.len) + 3) / 4;
        waits = 0;
        for (int k = 0; k < beats; k++) begin
            @(negedge clk);
            fs_valid = 1'b1; fs_data = pat(tag, k); fs_last = (k == beats - 1);
            fs_src_port = v.port; fs_len = v.len; fs_vlan_tag = v.vtag;
            fs_ip_csum_bad = v.ipf; fs_pkt_type = v.ptype;
            while (!fs_ready) begin
                if (k == 0) waits++;
                @(negedge clk);
            end
        end
        @(negedge clk);
        fs_valid = 1'b0; fs_last = 1'b0;
    endtask

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog (R1..R11 run): actual timeout expected completion");
        summary();
    end

    initial begin
        int          off;
        int          waits;
        logic [31:0] d, w0, capt, stored, st_exp;
        off = 0;
        repeat (3) @(negedge clk);
        // R1: quiet outputs in and after reset
        check("R1 fs_ready in reset", {31'b0, fs_ready}, 32'h0);
        check("R1 mem_req in reset", {31'b0, mem_req}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 mem_req idle", {31'b0, mem_req}, 32'h0);
        check("R1 irq idle", {30'b0, irq_rx_done, irq_no_desc}, 32'h0);
        check("R1 fs_ready idle", {31'b0, fs_ready}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            d = BASE + 32'(off);
            for (int w = 0; w < NB1; w++) poke(B1 + 32'(4 * w), SENT);
            for (int w = 0; w < NB2; w++) poke(B2 + 32'(4 * w), SENT);
            w0 = {v.own, 2'b00, v.eor, 3'b000, B1[24:0]};
            poke(d, w0);
            poke(d + 4, {v.ext, 6'b0, B2[24:0]});
            poke(d + 8, {5'b0, v.cap2, 5'b0, v.cap1});
            poke(d + 12, 32'h0);
            @(negedge clk); set_en = 1'b0; clr = 1'b1;
            @(negedge clk); clr = 1'b0;

            send_frame(v, i, waits);
            repeat (8) @(negedge clk);

            // expected image
            capt   = 32'(v.cap1) + (v.ext ? 32'(v.cap2) : 32'h0);
            stored = (32'(v.len) > capt) ? capt : 32'(v.len);
            for (int w = 0; w < NB1; w++) eb1[w] = SENT;
            for (int w = 0; w < NB2; w++) eb2[w] = SENT;
            if (v.own) begin
                for (int k = 0; 4 * k < int'(stored); k++) begin
                    if (4 * k < int'(v.cap1)) eb1[k] = pat(i, k);
                    else eb2[(4 * k - int'(v.cap1)) / 4] = pat(i, k);
                end
            end

            check("R10 fetch cycles before ready", 32'(waits), 32'd4);
            check("R1 R2 R6 R7 first fetch addr", rd_log[0], d);
            check("R2 second fetch addr", rd_log[1], d + 4);
            check("R2 third fetch addr", rd_log[2], d + 8);
            check("R2 read count", 32'(n_rd), 32'd3);
            if (v.own) begin
                st_exp = {5'b0, stored[10:0], 1'b0, v.port, 8'b0, v.ipf, v.vtag, v.ptype};
                check("R4 R9 status word", mem[(d + 12) >> 2], st_exp);
                check("R5 released word0", mem[d >> 2], {1'b0, w0[30:0]});
                check("R5 R11 done pulses", 32'(n_done), 32'd1);
                check("R11 no-desc pulses", 32'(n_nodesc), 32'd0);
                check("R3 R9 write count", 32'(n_wr), (stored + 3) / 4 + 2);
                off = v.eor ? 0 : off + 16;
            end else begin
                check("R7 no-desc pulses", 32'(n_nodesc), 32'd1);
                check("R7 R11 done pulses", 32'(n_done), 32'd0);
                check("R7 write count", 32'(n_wr), 32'd0);
                check("R7 word0 untouched", mem[d >> 2], w0);
                check("R7 status untouched", mem[(d + 12) >> 2], 32'h0);
            end
            for (int w = 0; w < NB1; w++)
                check("R3 R9 primary buffer word", mem[(B1 >> 2) + w], eb1[w]);
            for (int w = 0; w < NB2; w++)
                check("R8 R9 secondary buffer word", mem[(B2 >> 2) + w], eb2[w]);
        end

        // directed: pointer after the last release (R6) via one more dropped frame
        begin
            vec_t v;
            v = VECS[2];
            d = BASE + 32'(off);
            poke(d, {1'b0, 2'b00, 1'b0, 3'b000, B1[24:0]});
            @(negedge clk); set_en = 1'b0; clr = 1'b1;
            @(negedge clk); clr = 1'b0;
            send_frame(v, 9, waits);
            repeat (6) @(negedge clk);
            check("R6 advance after final release", rd_log[0], BASE + 32'h20);
            check("R7 R11 directed no-desc pulse", 32'(n_nodesc), 32'd1);
        end
        summary();
    end
endmodule